// File: doc/BRIEF.md
# Shared-Memory Atomic Update Unit

This block owns a small word-addressed scratchpad and carries out one shared-memory command at a time. A command is a 64-bit instruction word plus three 32-bit operand values: a base byte address and two data values. The instruction word selects the operation and carries the offsets. The register-number fields of the word name where those values came from, and this block does not use them. The block supports three kinds of work: a single aligned store, a store of two words at two separately offset addresses, and a 32-bit atomic read-modify-write. The atomic kind returns the word as it was before the update.

A size-limit register bounds the byte addresses a command may touch. It resets to all ones, which leaves the whole space open. A command whose encoding tag is wrong, whose opcode is not supported, or whose aligned address reaches the limit is dropped without any write and answered with a one-cycle error pulse. Commands arrive on a valid/ready pair. Ready is high only while the unit is idle, so there is never more than one command in flight.

Top module: `shm_atomic_unit`

## Requirements
- R1: The opcode is taken from instruction bits 25:18 and the encoding tag from bits 31:26, which must equal 6'b110110. Bits 63:32, 17 and 16 have no effect on the result.
- R2: A single-address command uses the 16-bit offset in bits 15:0. Its byte address is (base + offset) modulo 2^32 with bits 1:0 forced to zero. The scratchpad word index is taken from byte-address bits log2(WORDS)+1 down to 2, so higher bits wrap.
- R3: Opcode 13 stores D0 at the aligned address. It raises no result-valid, and ready returns after exactly one busy cycle.
- R4: Opcode 14 takes offset A from bits 7:0 and offset B from bits 15:8, multiplies each by four and adds each to the base. D0 is stored at the first aligned address and D1 at the second. When both addresses are equal, D1 is what remains. It has one busy cycle and no result-valid.
- R5: Opcode 0 stores mem+D0, opcode 1 stores mem−D0 and opcode 2 stores D0−mem, all modulo 2^32.
- R6: Opcode 3 stores mem+1 if D0 > mem (unsigned) and 0 otherwise. Opcode 4 stores mem−1 if D0 >= mem and mem != 0, and D0 otherwise.
- R7: Opcodes 5 and 6 store the signed 32-bit minimum and maximum of mem and D0. Opcodes 7 and 8 store the unsigned minimum and maximum.
- R8: Opcodes 9, 10 and 11 store mem AND D0, mem OR D0 and mem XOR D0. Opcode 12 stores (mem AND NOT D0) OR D1.
- R9: After an atomic (opcodes 0 to 12) is accepted, ready stays low for three cycles. Result-valid is high for exactly the third of those cycles, and the result port then carries the pre-update word.
- R10: A command is rejected when its aligned address is at or above the size limit. For opcode 14 this applies if either address is at or above the limit, and then neither word is written. A rejected command writes nothing, gives no result-valid, and raises the error output for the one busy cycle that follows acceptance. The limit loads from its data input when its write enable is high. The reset value 0xFFFFFFFF admits every address.
- R11: A command whose encoding tag is not 6'b110110 is rejected as in R10 and writes nothing.
- R12: A command with opcode 15 or above is rejected as in R10.
- R13: After reset, ready is high, result-valid and error are low, and the limit is 0xFFFFFFFF. Scratchpad contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and accepting |
| cmd_word | input | 64 | Instruction word |
| cmd_base | input | 32 | Base byte address value |
| cmd_d0 | input | 32 | First data operand value |
| cmd_d1 | input | 32 | Second data operand value |
| lim_we | input | 1 | Load the size limit |
| lim_data | input | 32 | New size limit |
| rsp_valid | output | 1 | Atomic result present |
| rsp_data | output | 32 | Word before the atomic update |
| err | output | 1 | Command rejected (one-cycle pulse) |

## Verification
The bench builds the unit with its default 32-bit data path and a 64-word scratchpad. At that size the word index covers byte addresses 0x00 to 0xFC before it wraps. This puts both the top-of-space address 0xFFFFFFFC and a base-plus-offset sum that overflows 32 bits within reach, along with limits set just at and below a tested address. Every atomic opcode is run from a known stored word, and the new word is read back through an atomic OR with zero. Dual stores are run with distinct offsets, with coinciding offsets, and with the second address straddling the limit.

// File: rtl/shm_pkg.sv
// Shared constants and types for the shared-memory atomic unit.
// Assumes a 64-bit instruction word with opcode in 25:18 and tag in 31:26.
package shm_pkg;
    localparam int unsigned INSN_W  = 64;
    localparam int unsigned OPC_W   = 8;
    localparam logic [5:0]  ENC_TAG = 6'b110110;

    localparam logic [OPC_W-1:0] OP_ADD    = 8'd0;
    localparam logic [OPC_W-1:0] OP_SUB    = 8'd1;
    localparam logic [OPC_W-1:0] OP_RSUB   = 8'd2;
    localparam logic [OPC_W-1:0] OP_INC    = 8'd3;
    localparam logic [OPC_W-1:0] OP_DEC    = 8'd4;
    localparam logic [OPC_W-1:0] OP_SMIN   = 8'd5;
    localparam logic [OPC_W-1:0] OP_SMAX   = 8'd6;
    localparam logic [OPC_W-1:0] OP_UMIN   = 8'd7;
    localparam logic [OPC_W-1:0] OP_UMAX   = 8'd8;
    localparam logic [OPC_W-1:0] OP_AND    = 8'd9;
    localparam logic [OPC_W-1:0] OP_OR     = 8'd10;
    localparam logic [OPC_W-1:0] OP_XOR    = 8'd11;
    localparam logic [OPC_W-1:0] OP_MSKOR  = 8'd12;
    localparam logic [OPC_W-1:0] OP_WRITE  = 8'd13;
    localparam logic [OPC_W-1:0] OP_WRITE2 = 8'd14;

    typedef enum logic [1:0] {
        K_ATOMIC = 2'd0,
        K_STORE1 = 2'd1,
        K_STORE2 = 2'd2,
        K_REJECT = 2'd3
    } shm_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CALC  = 3'd2,
        ST_WRITE = 3'd3,
        ST_STORE = 3'd4,
        ST_FAULT = 3'd5
    } shm_state_e;
endpackage

// File: rtl/shm_decode.sv
// Instruction decode and address check.
// Splits the instruction word, forms one or two dword-aligned byte
// addresses, and classifies the command as atomic, single store, dual
// store or reject (bad tag, unsupported opcode, or address at/over limit).
// Purely combinational; assumes base and limit are stable while sampled.
module shm_decode
    import shm_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned IDXW = 6
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [DW-1:0]     base,
    input  logic [DW-1:0]     limit,
    output shm_kind_e         kind,
    output logic [OPC_W-1:0]  opcode,
    output logic [IDXW-1:0]   idx0,
    output logic [IDXW-1:0]   idx1
);
    localparam logic [DW-1:0] ALIGN_MASK = ~DW'(3);

    logic [DW-1:0] sum_single, sum_a, sum_b;
    logic [DW-1:0] addr0, addr1;
    logic          tag_ok, is_dual, over;

    // Field extraction and address sums (all modulo 2^DW).
    always_comb begin
        opcode     = insn[25:18];
        tag_ok     = (insn[31:26] == ENC_TAG);
        is_dual    = (opcode == OP_WRITE2);
        sum_single = base + DW'(insn[15:0]);
        sum_a      = base + DW'({insn[7:0], 2'b00});
        sum_b      = base + DW'({insn[15:8], 2'b00});
        addr0      = (is_dual ? sum_a : sum_single) & ALIGN_MASK;
        addr1      = sum_b & ALIGN_MASK;
    end

    // Limit check over every address the command would touch.
    always_comb begin
        over = (addr0 >= limit) || (is_dual && (addr1 >= limit));
    end

    // Command classification.
    always_comb begin
        if (!tag_ok || over) begin
            kind = K_REJECT;
        end else if (opcode <= OP_MSKOR) begin
            kind = K_ATOMIC;
        end else if (opcode == OP_WRITE) begin
            kind = K_STORE1;
        end else if (is_dual) begin
            kind = K_STORE2;
        end else begin
            kind = K_REJECT;
        end
    end

    // Word indices, wrapping above the scratchpad depth.
    always_comb begin
        idx0 = addr0[IDXW+1:2];
        idx1 = addr1[IDXW+1:2];
    end
endmodule

// File: rtl/shm_alu.sv
// Atomic update arithmetic.
// Computes the new memory word from the old word and the two operands
// for opcodes 0..12. Combinational; other opcodes return the old word.
module shm_alu
    import shm_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [DW-1:0]    mem_old,
    input  logic [DW-1:0]    d0,
    input  logic [DW-1:0]    d1,
    output logic [DW-1:0]    mem_new
);
    logic s_less, u_less;

    // Signed and unsigned ordering of the operand against memory.
    always_comb begin
        s_less = $signed(d0) < $signed(mem_old);
        u_less = d0 < mem_old;
    end

    // Per-opcode update value.
    always_comb begin
        case (opcode)
            OP_ADD:   mem_new = mem_old + d0;
            OP_SUB:   mem_new = mem_old - d0;
            OP_RSUB:  mem_new = d0 - mem_old;
            OP_INC:   mem_new = (d0 > mem_old) ? mem_old + DW'(1) : '0;
            OP_DEC:   mem_new = (d0 >= mem_old && mem_old != '0) ? mem_old - DW'(1) : d0;
            OP_SMIN:  mem_new = s_less ? d0 : mem_old;
            OP_SMAX:  mem_new = s_less ? mem_old : d0;
            OP_UMIN:  mem_new = u_less ? d0 : mem_old;
            OP_UMAX:  mem_new = u_less ? mem_old : d0;
            OP_AND:   mem_new = mem_old & d0;
            OP_OR:    mem_new = mem_old | d0;
            OP_XOR:   mem_new = mem_old ^ d0;
            OP_MSKOR: mem_new = (mem_old & ~d0) | d1;
            default:  mem_new = mem_old;
        endcase
    end
endmodule

// File: rtl/shm_scratch.sv
// Word scratchpad with one asynchronous read port and two write ports.
// When both writes hit the same word in one cycle, port 1 wins.
// Contents are not reset.
module shm_scratch #(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 64,
    parameter int unsigned IDXW  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we0,
    input  logic [IDXW-1:0] widx0,
    input  logic [DW-1:0]   wdata0,
    input  logic            we1,
    input  logic [IDXW-1:0] widx1,
    input  logic [DW-1:0]   wdata1,
    input  logic [IDXW-1:0] ridx,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [WORDS];

    // Write ports; the later statement gives port 1 priority.
    always_ff @(posedge clk) begin
        if (we0) mem[widx0] <= wdata0;
        if (we1) mem[widx1] <= wdata1;
    end

    // Combinational read.
    always_comb begin
        rdata = mem[ridx];
    end
endmodule

// File: rtl/shm_atomic_unit.sv
// Shared-memory atomic update unit (top).
// Accepts one command when idle, then runs a store (one busy cycle),
// an atomic read/compute/write (three busy cycles, result on the last),
// or a reject (one busy cycle with err high). Holds the size limit.
// Assumes the operand values are held valid with cmd_valid.
module shm_atomic_unit
    import shm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [INSN_W-1:0] cmd_word,
    input  logic [DATA_W-1:0] cmd_base,
    input  logic [DATA_W-1:0] cmd_d0,
    input  logic [DATA_W-1:0] cmd_d1,
    input  logic              lim_we,
    input  logic [DATA_W-1:0] lim_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err
);
    localparam int unsigned IDXW = $clog2(WORDS);

    shm_state_e        state_q, state_d;
    shm_kind_e         dec_kind;
    logic [OPC_W-1:0]  dec_op, op_q;
    logic [IDXW-1:0]   dec_idx0, dec_idx1, idx0_q, idx1_q;
    logic [DATA_W-1:0] d0_q, d1_q, old_q, new_q, limit_q;
    logic [DATA_W-1:0] rd_word, alu_word, wr0_word;
    logic              fire, dual_q, wr0_en, wr1_en;

    shm_decode #(.DW(DATA_W), .IDXW(IDXW)) i_decode (
        .insn   (cmd_word),
        .base   (cmd_base),
        .limit  (limit_q),
        .kind   (dec_kind),
        .opcode (dec_op),
        .idx0   (dec_idx0),
        .idx1   (dec_idx1)
    );

    shm_alu #(.DW(DATA_W)) i_alu (
        .opcode  (op_q),
        .mem_old (old_q),
        .d0      (d0_q),
        .d1      (d1_q),
        .mem_new (alu_word)
    );

    shm_scratch #(.DW(DATA_W), .WORDS(WORDS), .IDXW(IDXW)) i_scratch (
        .clk    (clk),
        .we0    (wr0_en),
        .widx0  (idx0_q),
        .wdata0 (wr0_word),
        .we1    (wr1_en),
        .widx1  (idx1_q),
        .wdata1 (d1_q),
        .ridx   (idx0_q),
        .rdata  (rd_word)
    );

    // Handshake and outputs follow the state.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        fire      = cmd_valid && cmd_ready;
        rsp_valid = (state_q == ST_WRITE);
        rsp_data  = old_q;
        err       = (state_q == ST_FAULT);
    end

    // Scratchpad write enables: atomic write-back or store.
    always_comb begin
        wr0_en   = (state_q == ST_WRITE) || (state_q == ST_STORE);
        wr0_word = (state_q == ST_WRITE) ? new_q : d0_q;
        wr1_en   = (state_q == ST_STORE) && dual_q;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    case (dec_kind)
                        K_ATOMIC: state_d = ST_READ;
                        K_STORE1,
                        K_STORE2: state_d = ST_STORE;
                        default:  state_d = ST_FAULT;
                    endcase
                end
            end
            ST_READ:  state_d = ST_CALC;
            ST_CALC:  state_d = ST_WRITE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Size-limit register; reset opens the full address space.
    always_ff @(posedge clk) begin
        if (!rst_n)      limit_q <= '1;
        else if (lim_we) limit_q <= lim_data;
    end

    // Capture the decoded command on acceptance.
    always_ff @(posedge clk) begin
        if (fire) begin
            op_q   <= dec_op;
            idx0_q <= dec_idx0;
            idx1_q <= dec_idx1;
            d0_q   <= cmd_d0;
            d1_q   <= cmd_d1;
            dual_q <= (dec_kind == K_STORE2);
        end
    end

    // Atomic datapath: read the old word, then compute the new one.
    always_ff @(posedge clk) begin
        if (state_q == ST_READ) old_q <= rd_word;
        if (state_q == ST_CALC) new_q <= alu_word;
    end
endmodule

// File: rtl/shm_atomic_checker.sv
// Protocol checker for shm_atomic_unit, bound to every instance.
// Observes only ports; insn_hi carries instruction bits 31:18.
module shm_atomic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [13:0] insn_hi,
    input logic        rsp_valid,
    input logic        err
);
    logic fire, tag_ok;

    // Acceptance and tag recognition as seen at the ports.
    always_comb begin
        fire   = cmd_valid && cmd_ready;
        tag_ok = (insn_hi[13:8] == 6'b110110);
    end

    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!cmd_ready && $past(!cmd_ready) && $past(!cmd_ready, 2))); // R9
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(fire, 3)); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rsp_valid); // R10
    AST_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !tag_ok) |=> err); // R11
    AST_UNSUP_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tag_ok && insn_hi[7:0] > 8'd14) |=> err); // R12
    AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (insn_hi[7:0] == 8'd13 || insn_hi[7:0] == 8'd14)) |=> !rsp_valid); // R3
    AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (cmd_ready && !err)); // R10
endmodule

bind shm_atomic_unit shm_atomic_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .insn_hi   (cmd_word[31:18]),
    .rsp_valid (rsp_valid),
    .err       (err)
);

// File: tb/test_shm_atomic_unit.sv
`timescale 1ns/1ps
module test_shm_atomic_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_word = '0;
    logic [31:0] cmd_base = '0, cmd_d0 = '0, cmd_d1 = '0;
    logic        lim_we = 1'b0;
    logic [31:0] lim_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shm_atomic_unit i_shm_atomic_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .cmd_base(cmd_base), .cmd_d0(cmd_d0), .cmd_d1(cmd_d1),
        .lim_we(lim_we), .lim_data(lim_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .err(err)
    );

    // Vector: {opcode, initial word, d0, d1, expected new word}
    localparam int NV = 19;
    localparam logic [135:0] VEC [NV] = '{
        {8'd0,  32'h00000005, 32'h00000007, 32'h0, 32'h0000000C},
        {8'd0,  32'hFFFFFFFF, 32'h00000002, 32'h0, 32'h00000001},
        {8'd1,  32'h00000005, 32'h00000007, 32'h0, 32'hFFFFFFFE},
        {8'd2,  32'h00000005, 32'h00000007, 32'h0, 32'h00000002},
        {8'd3,  32'h00000003, 32'h0000000A, 32'h0, 32'h00000004},
        {8'd3,  32'h0000000A, 32'h0000000A, 32'h0, 32'h00000000},
        {8'd4,  32'h00000005, 32'h00000009, 32'h0, 32'h00000004},
        {8'd4,  32'h00000000, 32'h00000009, 32'h0, 32'h00000009},
        {8'd4,  32'h00000009, 32'h00000005, 32'h0, 32'h00000005},
        {8'd5,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'hFFFFFFFF},
        {8'd6,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h00000001},
        {8'd7,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h00000001},
        {8'd8,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'hFFFFFFFF},
        {8'd9,  32'h0000F0F0, 32'h0000FF00, 32'h0, 32'h0000F000},
        {8'd10, 32'h0000F0F0, 32'h0000FF00, 32'h0, 32'h0000FFF0},
        {8'd11, 32'h0000F0F0, 32'h0000FF00, 32'h0, 32'h00000FF0},
        {8'd12, 32'hFFFF0000, 32'h00FF0000, 32'h0000000F, 32'hFF00000F},
        {8'd5,  32'h00000003, 32'h80000000, 32'h0, 32'h80000000},
        {8'd8,  32'h00000003, 32'h80000000, 32'h0, 32'h80000000}
    };

    function automatic logic [63:0] mk(input logic [7:0] op, input logic [15:0] off);
        return {32'h0, 6'b110110, op, 2'b00, off};
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op <= 8'd2) return "R5";
        if (op <= 8'd4) return "R6";
        if (op <= 8'd8) return "R7";
        return "R8";
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    logic        r_rsp, r_err;
    logic [31:0] r_val;
    int          r_busy, r_pos;

    // Offer one command, then watch up to eight cycles until ready returns.
    task automatic run_cmd(input logic [63:0] w, input logic [31:0] a, input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w; cmd_base = a; cmd_d0 = d0; cmd_d1 = d1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        r_rsp = 1'b0; r_err = 1'b0; r_val = '0; r_busy = 0; r_pos = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (rsp_valid) begin r_rsp = 1'b1; r_val = rsp_data; r_pos = k; end
            if (err) r_err = 1'b1;
            if (cmd_ready) break;
            r_busy++;
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] v);
        run_cmd(mk(8'd13, 16'h0), a, v, 32'h0);
    endtask

    // Read back through an atomic OR with zero (word unchanged).
    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        run_cmd(mk(8'd10, 16'h0), a, 32'h0, 32'h0);
        v = r_val;
    endtask

    task automatic set_lim(input logic [31:0] v);
        @(negedge clk); lim_we = 1'b1; lim_data = v;
        @(negedge clk); lim_we = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(cmd_ready === 1'b1, "R13", 32'(cmd_ready), 32'h1);
        check(rsp_valid === 1'b0, "R13", 32'(rsp_valid), 32'h0);
        check(err === 1'b0, "R13", 32'(err), 32'h0);

        // Vector table of atomics
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  op;
            logic [31:0] ini, d0, d1, exp, a;
            {op, ini, d0, d1, exp} = VEC[i];
            a = 32'(i * 4);
            wr(a, ini);
            run_cmd(mk(op, 16'h0), a, d0, d1);
            // R9 pre-update value, timing
            check(r_rsp && r_val == ini, "R9", r_val, ini);
            check(r_busy == 3 && r_pos == 3, "R9", 32'(r_busy * 16 + r_pos), 32'h33);
            rd(a, v);
            check(v == exp, req_of(op), v, exp);
        end

        // R3 plain store: one busy cycle, no response
        wr(32'h60, 32'hCAFE0001);
        check(!r_rsp && !r_err && r_busy == 1, "R3", 32'(r_busy), 32'h1);
        rd(32'h60, v);
        check(v == 32'hCAFE0001, "R3", v, 32'hCAFE0001);

        // R2 unaligned sum is aligned down
        run_cmd(mk(8'd13, 16'h0002), 32'h00000061, 32'h11112222, 32'h0);
        rd(32'h60, v);
        check(v == 32'h11112222, "R2", v, 32'h11112222);
        // R2 base + offset wraps modulo 2^32, index wraps above depth
        run_cmd(mk(8'd13, 16'h0014), 32'hFFFFFFF0, 32'h0BADF00D, 32'h0);
        rd(32'h104, v);
        check(v == 32'h0BADF00D, "R2", v, 32'h0BADF00D);

        // R1 ignored fields (register numbers, bits 17:16)
        run_cmd(mk(8'd13, 16'h0) | 64'hABCD_EF12_0003_0000, 32'h64, 32'h5A5A5A5A, 32'h0);
        check(!r_err && r_busy == 1, "R1", 32'(r_err), 32'h0);
        rd(32'h64, v);
        check(v == 32'h5A5A5A5A, "R1", v, 32'h5A5A5A5A);

        // R4 dual store with scaled offsets
        wr(32'h88, 32'h77777777);
        run_cmd(mk(8'd14, {8'd3, 8'd1}), 32'h80, 32'hAAAA0000, 32'hBBBB0000);
        check(!r_rsp && !r_err && r_busy == 1, "R4", 32'(r_busy), 32'h1);
        rd(32'h84, v);
        check(v == 32'hAAAA0000, "R4", v, 32'hAAAA0000);
        rd(32'h8C, v);
        check(v == 32'hBBBB0000, "R4", v, 32'hBBBB0000);
        rd(32'h88, v);
        check(v == 32'h77777777, "R4", v, 32'h77777777);
        // R4 coinciding addresses: second operand remains
        run_cmd(mk(8'd14, {8'd2, 8'd2}), 32'h80, 32'h12121212, 32'h34343434);
        rd(32'h88, v);
        check(v == 32'h34343434, "R4", v, 32'h34343434);

        // R10 reset limit admits the top address
        wr(32'hFFFFFFFC, 32'h600DD00D);
        check(!r_err, "R10", 32'(r_err), 32'h0);
        rd(32'hFC, v);
        check(v == 32'h600DD00D, "R10", v, 32'h600DD00D);

        // R10 limit just at tested address
        wr(32'h40, 32'h40404040);
        wr(32'h30, 32'h30303030);
        set_lim(32'h40);
        wr(32'h40, 32'hDEADBEEF);
        check(r_err && r_busy == 1 && !r_rsp, "R10", 32'(r_err), 32'h1);
        run_cmd(mk(8'd0, 16'h0), 32'h40, 32'h1, 32'h0);
        check(r_err && !r_rsp, "R10", 32'(r_rsp), 32'h0);
        wr(32'h3C, 32'h3C3C3C3C);
        check(!r_err, "R10", 32'(r_err), 32'h0);
        run_cmd(mk(8'd14, {8'd4, 8'd0}), 32'h30, 32'h99999999, 32'h88888888);
        check(r_err, "R10", 32'(r_err), 32'h1);
        rd(32'h30, v);
        check(v == 32'h30303030, "R10", v, 32'h30303030);
        set_lim(32'hFFFFFFFF);
        rd(32'h40, v);
        check(v == 32'h40404040, "R10", v, 32'h40404040);

        // R11 bad encoding tag
        run_cmd({32'h0, 6'b110111, 8'd13, 18'h0}, 32'h40, 32'hDEADBEEF, 32'h0);
        check(r_err && r_busy == 1, "R11", 32'(r_err), 32'h1);
        rd(32'h40, v);
        check(v == 32'h40404040, "R11", v, 32'h40404040);

        // R12 unsupported opcodes
        run_cmd(mk(8'd15, 16'h0), 32'h40, 32'h1, 32'h1);
        check(r_err && !r_rsp, "R12", 32'(r_err), 32'h1);
        run_cmd(mk(8'd54, 16'h0), 32'h40, 32'h1, 32'h1);
        check(r_err && !r_rsp, "R12", 32'(r_err), 32'h1);
        rd(32'h40, v);
        check(v == 32'h40404040, "R12", v, 32'h40404040);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule